// File: doc/BRIEF.md
# Trip-Count Aged Victim Cache Set

This block keeps the replacement state for a single set of an exclusive last-level cache. That cache only receives lines that the level above casts out. Each of the ways holds a valid flag, an address tag, a one-bit trip marker and a two-bit age. The trip marker is 0 for a line that came straight from memory. It is 1 for a line that has already gone up to the level above and come back at least once.

A lookup compares the request tag with every way and reports the result in the same cycle. A line that hits leaves this set at the next clock edge, because the level above takes ownership of it, and its trip marker is returned with the hit. A fill places a line cast out from above. If a way is free, the fill uses it. Otherwise the fill replaces the youngest line, which is the one with the lowest age, and reports that line's tag and trip marker one cycle later. The insertion age depends on the trip marker, and an external select can drop the default age of fresh lines to zero so that an outer policy can compare two insertion choices.

Top module: `tca_set`

## Requirements
- R1: After synchronous reset every way is empty: every lookup misses, `evict_valid` is 0 and `fill_way` is 0.
- R2: In the cycle that `lk_valid` is high, `lk_hit` is 1 only when a valid way holds `lk_tag`; `lk_way` then gives the lowest such way and `lk_tc` gives its trip marker.
- R3: A lookup that hits at a clock edge frees that way, so a later lookup of the same tag misses.
- R4: A fill takes the lowest-numbered free way. The cycle after such a fill, `fill_way` shows that way and `evict_valid` is 0.
- R5: A line filled with trip marker 1 gets age 3.
- R6: A line filled with trip marker 0 gets age 1, or age 0 when `fill_age0` is high. `fill_age0` has no effect when the trip marker is 1.
- R7: A fill into a full set replaces the lowest-numbered way among those with the smallest age. The cycle after the fill, `evict_valid` is 1, `evict_tag` and `evict_tc` hold the replaced line's values and `fill_way` gives the way.
- R8: On such a replacement, every other valid line has the smallest age added to its own age, saturating at 3.
- R9: When a lookup and a fill present the same tag in the same cycle, the lookup reports the hit and frees the way first. The fill is then placed with the way already free, so it causes no eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Lookup tag |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_way | output | $clog2(NUM_WAYS) | Way that hit |
| lk_tc | output | 1 | Trip marker of the line that hit |
| fill_valid | input | 1 | Fill request |
| fill_tag | input | TAG_W | Tag of the incoming line |
| fill_tc | input | 1 | Trip marker of the incoming line |
| fill_age0 | input | 1 | Insert a trip-0 line at age 0 instead of 1 |
| fill_way | output | $clog2(NUM_WAYS) | Way written by the last fill (registered) |
| evict_valid | output | 1 | The last fill displaced a line (registered) |
| evict_tag | output | TAG_W | Tag of the displaced line |
| evict_tc | output | 1 | Trip marker of the displaced line |

## Verification
Ages cannot be read at the ports, so the hardest case to reach is the saturating age shift of a replacement whose smallest age is above zero. The stimulus first fills all sixteen ways with a mix of ages 0, 1 and 3. It then uses replacements to remove the age-0 lines until the smallest age is 1 and later 2, and it raises every surviving line to 3. The order of the evictions that follow shows whether each shift was applied and where it saturated. A same-cycle lookup and fill of one tag also checks the lookup-before-fill ordering at a full set.

// File: rtl/tca_pkg.sv
package tca_pkg;
  typedef logic [1:0] age_t;
  localparam age_t AGE_TOP   = 2'd3;
  localparam age_t AGE_FRESH = 2'd1;
  localparam age_t AGE_LOW   = 2'd0;
endpackage

// File: rtl/tca_match.sv
module tca_match #(
  parameter int NUM_WAYS = 16,
  parameter int TAG_W    = 20,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]            valid,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]               key,
  output logic [NUM_WAYS-1:0]            hit_vec,
  output logic                           hit,
  output logic [WAY_W-1:0]               hit_way
);
  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) begin
      hit_vec[i] = valid[i] && (tags[i] == key);
    end
  end

  assign hit = |hit_vec;

  // lowest matching way wins
  always_comb begin
    hit_way = '0;
    for (int i = NUM_WAYS-1; i >= 0; i--) begin
      if (hit_vec[i]) hit_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/tca_victim.sv
module tca_victim #(
  parameter int NUM_WAYS = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]        valid,
  input  tca_pkg::age_t [NUM_WAYS-1:0] ages,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way,
  output tca_pkg::age_t              min_age,
  output logic [WAY_W-1:0]           vic_way
);
  import tca_pkg::*;

  assign has_free = ~&valid;

  always_comb begin
    free_way = '0;
    for (int i = NUM_WAYS-1; i >= 0; i--) begin
      if (!valid[i]) free_way = WAY_W'(i);
    end
  end

  always_comb begin
    min_age = AGE_TOP;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (valid[i] && ages[i] < min_age) min_age = ages[i];
    end
  end

  always_comb begin
    vic_way = '0;
    for (int i = NUM_WAYS-1; i >= 0; i--) begin
      if (valid[i] && ages[i] == min_age) vic_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/tca_set.sv
module tca_set #(
  parameter int NUM_WAYS = 16,
  parameter int TAG_W    = 20,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  output logic             lk_tc,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_tc,
  input  logic             fill_age0,
  output logic [WAY_W-1:0] fill_way,
  output logic             evict_valid,
  output logic [TAG_W-1:0] evict_tag,
  output logic             evict_tc
);
  import tca_pkg::*;

  logic [NUM_WAYS-1:0]            valid_q;
  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q;
  logic [NUM_WAYS-1:0]            tc_q;
  age_t [NUM_WAYS-1:0]            age_q;

  logic [NUM_WAYS-1:0] hit_vec;
  logic                hit_any;
  logic [WAY_W-1:0]    hit_way;
  logic [NUM_WAYS-1:0] valid_mid;
  logic                free_any;
  logic [WAY_W-1:0]    free_way;
  logic [WAY_W-1:0]    vic_way;
  age_t                min_age;
  logic [WAY_W-1:0]    tgt_way;
  age_t                ins_age;

  tca_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
    .valid   (valid_q),
    .tags    (tag_q),
    .key     (lk_tag),
    .hit_vec (hit_vec),
    .hit     (hit_any),
    .hit_way (hit_way)
  );

  assign lk_hit = lk_valid && hit_any;
  assign lk_way = hit_way;
  assign lk_tc  = tc_q[hit_way];

  // lookup acts before fill: the hit way is already free for the fill
  assign valid_mid = lk_hit ? (valid_q & ~hit_vec) : valid_q;

  tca_victim #(.NUM_WAYS(NUM_WAYS)) u_victim (
    .valid    (valid_mid),
    .ages     (age_q),
    .has_free (free_any),
    .free_way (free_way),
    .min_age  (min_age),
    .vic_way  (vic_way)
  );

  assign tgt_way = free_any ? free_way : vic_way;
  assign ins_age = fill_tc ? AGE_TOP : (fill_age0 ? AGE_LOW : AGE_FRESH);

  function automatic age_t sat_add(input age_t a, input age_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > 3'd3) ? AGE_TOP : s[1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      tag_q       <= '0;
      tc_q        <= '0;
      age_q       <= '0;
      fill_way    <= '0;
      evict_valid <= 1'b0;
      evict_tag   <= '0;
      evict_tc    <= 1'b0;
    end else begin
      valid_q     <= valid_mid;
      evict_valid <= 1'b0;
      if (fill_valid) begin
        if (!free_any) begin
          for (int i = 0; i < NUM_WAYS; i++) begin
            if (WAY_W'(i) != vic_way) age_q[i] <= sat_add(age_q[i], min_age);
          end
        end
        valid_q[tgt_way] <= 1'b1;
        tag_q[tgt_way]   <= fill_tag;
        tc_q[tgt_way]    <= fill_tc;
        age_q[tgt_way]   <= ins_age;
        fill_way         <= tgt_way;
        evict_valid      <= !free_any;
        evict_tag        <= tag_q[vic_way];
        evict_tc         <= tc_q[vic_way];
      end
    end
  end

  AST_HIT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && !fill_valid) |=> !valid_q[$past(lk_way)]); // R3

  AST_FREE_NO_EVICT: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && free_any) |=> !evict_valid); // R4

  AST_TRIP_AGE: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_tc) |=> (valid_q[fill_way] && age_q[fill_way] == AGE_TOP)); // R5

  AST_FRESH_AGE: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !fill_tc) |=> (age_q[fill_way] == ($past(fill_age0) ? AGE_LOW : AGE_FRESH))); // R6

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_chk
    AST_VICTIM_MIN: assert property (@(posedge clk) disable iff (rst)
      (fill_valid && !free_any) |-> (age_q[vic_way] <= age_q[g])); // R7

    AST_AGE_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (fill_valid && !free_any && vic_way != WAY_W'(g)) |=>
      (age_q[g] >= $past(age_q[g]) &&
       (age_q[g] == AGE_TOP || (age_q[g] - $past(age_q[g])) == $past(min_age)))); // R8
  end
endmodule

// File: tb/tca_set_bench.sv
module tca_set_bench;
  localparam int CLK_P = 10;
  localparam int NW    = 16;
  localparam int TW    = 12;
  localparam int WW    = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [TW-1:0] lk_tag = '0;
  logic          lk_hit;
  logic [WW-1:0] lk_way;
  logic          lk_tc;
  logic          fill_valid = 1'b0;
  logic [TW-1:0] fill_tag = '0;
  logic          fill_tc = 1'b0;
  logic          fill_age0 = 1'b0;
  logic [WW-1:0] fill_way;
  logic          evict_valid;
  logic [TW-1:0] evict_tag;
  logic          evict_tc;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  tca_set #(.NUM_WAYS(NW), .TAG_W(TW)) u_tca_set (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_way(lk_way), .lk_tc(lk_tc),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_tc(fill_tc), .fill_age0(fill_age0),
    .fill_way(fill_way), .evict_valid(evict_valid), .evict_tag(evict_tag), .evict_tc(evict_tc)
  );

  always #(CLK_P/2) clk = ~clk;

  // {tag, tc, age0, evicted tag, evicted tc, way}
  localparam int VN = 11;
  localparam logic [30:0] VEC [VN] = '{
    {12'h200, 1'b0, 1'b0, 12'h104, 1'b0, 4'd4},
    {12'h201, 1'b1, 1'b0, 12'h105, 1'b0, 4'd5},
    {12'h202, 1'b0, 1'b1, 12'h106, 1'b0, 4'd6},
    {12'h203, 1'b0, 1'b0, 12'h202, 1'b0, 4'd6},
    {12'h204, 1'b1, 1'b0, 12'h107, 1'b0, 4'd7},
    {12'h205, 1'b0, 1'b1, 12'h200, 1'b0, 4'd4},
    {12'h206, 1'b1, 1'b0, 12'h205, 1'b0, 4'd4},
    {12'h207, 1'b0, 1'b0, 12'h203, 1'b0, 4'd6},
    {12'h208, 1'b1, 1'b0, 12'h207, 1'b0, 4'd6},
    {12'h209, 1'b0, 1'b0, 12'h100, 1'b1, 4'd0},
    {12'h20A, 1'b0, 1'b0, 12'h209, 1'b0, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [TW-1:0] t, input logic tc, input logic a0);
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = t; fill_tc = tc; fill_age0 = a0;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // lookup withdrawn before the edge: observes without freeing the way
  task automatic peek(input logic [TW-1:0] t);
    @(negedge clk);
    lk_valid = 1'b1; lk_tag = t;
    #1;
  endtask

  task automatic peek_end();
    lk_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        chk(1'b0, "watchdog", cycles, 20000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(evict_valid == 1'b0, "R1 evict_valid", evict_valid, 0);
    chk(fill_way == '0, "R1 fill_way", fill_way, 0);
    peek(12'h100);
    chk(lk_hit == 1'b0, "R1 lookup", lk_hit, 0);
    peek_end();

    // R4 fill empty set: ways in order, no eviction; R5/R6 ages set here
    for (int i = 0; i < NW; i++) begin
      do_fill(12'h100 + TW'(i), (i < 4), (i >= 4 && i < 8));
      chk(fill_way == WW'(i), "R4 fill_way", fill_way, i);
      chk(evict_valid == 1'b0, "R4 no evict", evict_valid, 0);
    end

    // R5 R6 R7 R8 replacement table
    for (int v = 0; v < VN; v++) begin
      do_fill(VEC[v][30:19], VEC[v][18], VEC[v][17]);
      chk(evict_valid == 1'b1, "R7 evict_valid", evict_valid, 1);
      chk(evict_tag == VEC[v][16:5], "R7 R8 evict_tag", evict_tag, VEC[v][16:5]);
      chk(evict_tc == VEC[v][4], "R7 evict_tc", evict_tc, VEC[v][4]);
      chk(fill_way == VEC[v][3:0], "R7 fill_way", fill_way, VEC[v][3:0]);
    end

    // R2 lookups
    peek(12'h103);
    chk(lk_hit == 1'b1, "R2 hit", lk_hit, 1);
    chk(lk_way == 4'd3, "R2 way", lk_way, 3);
    chk(lk_tc == 1'b1, "R2 tc", lk_tc, 1);
    peek_end();
    peek(12'h10F);
    chk(lk_hit == 1'b1 && lk_way == 4'd15, "R2 hit way15", lk_way, 15);
    chk(lk_tc == 1'b0, "R2 tc0", lk_tc, 0);
    peek_end();
    peek(12'h104);
    chk(lk_hit == 1'b0, "R2 miss", lk_hit, 0);
    peek_end();
    @(negedge clk);
    lk_tag = 12'h10F; #1;
    chk(lk_hit == 1'b0, "R2 no request no hit", lk_hit, 0);

    // R3 hit frees the way
    peek(12'h103);
    chk(lk_hit == 1'b1, "R3 hit", lk_hit, 1);
    @(negedge clk);
    lk_valid = 1'b0;
    peek(12'h103);
    chk(lk_hit == 1'b0, "R3 gone", lk_hit, 0);
    peek_end();
    do_fill(12'h300, 1'b0, 1'b0);
    chk(fill_way == 4'd3, "R3 R4 reuse way", fill_way, 3);
    chk(evict_valid == 1'b0, "R4 no evict", evict_valid, 0);

    // R9 same-cycle lookup and fill at a full set
    @(negedge clk);
    lk_valid = 1'b1; lk_tag = 12'h10F;
    fill_valid = 1'b1; fill_tag = 12'h10F; fill_tc = 1'b1; fill_age0 = 1'b0;
    #1;
    chk(lk_hit == 1'b1 && lk_way == 4'd15, "R9 lookup first", lk_way, 15);
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    chk(evict_valid == 1'b0, "R9 no evict", evict_valid, 0);
    chk(fill_way == 4'd15, "R9 fill way", fill_way, 15);
    peek(12'h10F);
    chk(lk_hit == 1'b1 && lk_tc == 1'b1, "R9 refilled", lk_tc, 1);
    peek_end();

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(evict_valid == 1'b0, "R1 evict after reset", evict_valid, 0);
    peek(12'h10F);
    chk(lk_hit == 1'b0, "R1 empty after reset", lk_hit, 0);
    peek_end();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule